// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM Core

This block models a synchronous static memory with 18-bit words split into two 9-bit byte lanes. Every control, address and write-data input is captured on the rising clock edge. Read data then passes through a second, output register. A bus master opens an access with one of two active-low address strobes while the three chip enables select the device. It can then walk a four-beat burst with the advance input, or hold the current beat. Byte-granular or whole-word writes are applied through a global write enable and per-lane write enables.

The two strobes differ in write latency. An access opened by the processor strobe always begins as a read, and any write to that address happens on the next clock. An access opened by the controller strobe writes in the same cycle it is opened. The data pad is split into separate input, output and output-enable ports. The output enable is the registered read-valid gated by the asynchronous output-enable input.

Top module: `sram_pipe_burst`

## Requirements
- R1: An access starts only when a strobe is sampled low and all chip enables are active (`ce1_n`=0, `ce2`=1, `ce3_n`=0). `adsp_n` is ignored while `ce1_n` is 1. A strobe taken with the chip not selected is a deselect.
- R2: When `adsp_n` and `adsc_n` are both sampled low, only the processor strobe acts. The cycle is a read, and no write takes place whatever the write enables are.
- R3: A processor-strobe start is a read, and its write enables and `adv_n` are ignored. A following strobe-free cycle with write enables active and `adv_n`=1 writes `din` to that same address.
- R4: A controller-strobe start (`adsp_n`=1) with write enables active writes the `din` sampled on that same edge.
- R5: Write enables are decoded as follows. `gw_n`=0 writes both lanes. Otherwise, with `bwe_n`=0, bit i of `bw_n` low writes lane i (lane 0 = `din[8:0]`, lane 1 = `din[17:9]`). Lanes that are not written keep their contents.
- R6: Read data for an address registered at edge k is on `dout` after edge k+1.
- R7: A deselect sampled at an edge drops `dout_en` after that same edge. The first cycle of a read that follows a deselect keeps `dout_en` low.
- R8: `dout_en` is low after any edge where a write cycle is sampled, even with `oe_n`=0.
- R9: With both strobes high during a burst, `adv_n`=0 moves to the next burst address and `adv_n`=1 keeps the current one.
- R10: With step s counted from the start address, the two low address bits are (a+s) mod 4 when `burst_linear`=1 and a XOR s when `burst_linear`=0. The upper address bits never change within a burst.
- R11: After reset the device is deselected, with `dout_en` low.
- R12: `oe_n`=1 holds `dout_en` low without any clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | ADDR_W | Word address, sampled on a start |
| adsp_n | input | 1 | Processor address strobe, active low |
| adsc_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| ce1_n | input | 1 | Chip enable, active low, also gates `adsp_n` |
| ce2 | input | 1 | Chip enable, active high |
| ce3_n | input | 1 | Chip enable, active low |
| gw_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Byte-write enable, active low |
| bw_n | input | LANES | Per-lane write selects, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| burst_linear | input | 1 | 1 selects linear burst order, 0 interleaved |
| din | input | LANES*LANE_W | Write data |
| dout | output | LANES*LANE_W | Registered read data |
| dout_en | output | 1 | Output drive enable for the data pad |

## Verification
The whole array is loaded with arithmetic patterns and read back with back-to-back processor-strobe reads, which separates address decoding from pipeline latency. Bursts are started from each of the four low-address values in both orders, then suspended and closed with a deselect. A wrong order or a wrong wrap point shows up as a wrong word on a specific beat. All sixteen combinations of global write, byte-write enable and lane selects are applied to one location and read back, which shows lane masking and the read-versus-write decode apart. Directed cases cover strobe priority, the processor-strobe write delay, the first-chip-enable gating and the asynchronous output enable.

// File: rtl/sram_pkg.sv
package sram_pkg;

    // Kind of access decoded for one clock
    typedef enum logic [1:0] {
        ACC_NONE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2,
        ACC_DESEL = 2'd3
    } acc_kind_e;

endpackage

// File: rtl/sram_cycle_decode.sv
module sram_cycle_decode
    import sram_pkg::*;
#(
    parameter int LANES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adsp_n,
    input  logic             adsc_n,
    input  logic             adv_n,
    input  logic             ce1_n,
    input  logic             ce2,
    input  logic             ce3_n,
    input  logic             gw_n,
    input  logic             bwe_n,
    input  logic [LANES-1:0] bw_n,
    input  logic             burst_active,
    output acc_kind_e        kind,
    output logic             load_base,
    output logic             advance,
    output logic [LANES-1:0] lane_we
);

    logic selected;
    logic proc_seen;
    logic ctrl_seen;
    logic any_write;

    always_comb begin
        selected  = !ce1_n && ce2 && !ce3_n;
        // processor strobe only counts while the first enable is low
        proc_seen = !adsp_n && !ce1_n;
        ctrl_seen = !proc_seen && !adsc_n;

        if (!gw_n) begin
            lane_we = '1;
        end else if (!bwe_n) begin
            lane_we = ~bw_n;
        end else begin
            lane_we = '0;
        end
        any_write = |lane_we;

        kind      = ACC_NONE;
        load_base = 1'b0;
        advance   = 1'b0;

        if (proc_seen) begin
            if (selected) begin
                kind      = ACC_READ;
                load_base = 1'b1;
            end else begin
                kind = ACC_DESEL;
            end
        end else if (ctrl_seen) begin
            if (selected) begin
                kind      = any_write ? ACC_WRITE : ACC_READ;
                load_base = 1'b1;
            end else begin
                kind = ACC_DESEL;
            end
        end else if (burst_active) begin
            kind    = any_write ? ACC_WRITE : ACC_READ;
            advance = !adv_n;
        end

        // processor starts never write in their first cycle
        if (proc_seen) begin
            lane_we = '0;
        end
    end

    // R1: with the first enable high and the controller strobe idle nothing starts
    a_r1_ce1_gates_proc: assert property (@(posedge clk) disable iff (!rst_n)
        (ce1_n && adsc_n) |-> !load_base);

    // R2: processor strobe honoured first, and it never writes
    a_r2_proc_priority: assert property (@(posedge clk) disable iff (!rst_n)
        (!adsp_n && !ce1_n) |-> (kind != ACC_WRITE && lane_we == '0));

    // R5: global write reaches every lane of a write cycle
    a_r5_global_all_lanes: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == ACC_WRITE && !gw_n) |-> (&lane_we));

    // R9: no address step on a start or while idle
    a_r9_no_step_on_start: assert property (@(posedge clk) disable iff (!rst_n)
        load_base |-> !advance);

endmodule

// File: rtl/sram_burst_addr.sv
module sram_burst_addr #(
    parameter int ADDR_W  = 6,
    parameter int BURST_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              advance,
    input  logic              clear,
    input  logic              linear,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] acc_addr,
    output logic              active
);

    localparam int HI_W = ADDR_W - BURST_W;

    typedef struct packed {
        logic [ADDR_W-1:0]  base;
        logic [BURST_W-1:0] step;
        logic               active;
    } burst_t;

    burst_t bs_d, bs_q;
    logic [BURST_W-1:0] step_eff;
    logic [BURST_W-1:0] low_bits;

    always_comb begin
        bs_d     = bs_q;
        step_eff = advance ? bs_q.step + 1'b1 : bs_q.step;
        if (linear) begin
            low_bits = bs_q.base[BURST_W-1:0] + step_eff;
        end else begin
            low_bits = bs_q.base[BURST_W-1:0] ^ step_eff;
        end

        if (load) begin
            acc_addr    = addr_in;
            bs_d.base   = addr_in;
            bs_d.step   = '0;
            bs_d.active = 1'b1;
        end else begin
            acc_addr  = {bs_q.base[ADDR_W-1 -: HI_W], low_bits};
            bs_d.step = step_eff;
            if (clear) begin
                bs_d.active = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bs_q <= '0;
        end else begin
            bs_q <= bs_d;
        end
    end

    assign active = bs_q.active;

    // R9: advance steps the counter by one
    a_r9_step_once: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !load) |=> (bs_q.step == $past(bs_q.step) + 1'b1));

    // R9: without advance the counter holds
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!advance && !load) |=> (bs_q.step == $past(bs_q.step)));

    // R10: upper address bits are fixed inside a burst
    a_r10_upper_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        (bs_q.active && !load) |->
            (acc_addr[ADDR_W-1 -: HI_W] == bs_q.base[ADDR_W-1 -: HI_W]));

endmodule

// File: rtl/sram_byte_array.sv
module sram_byte_array #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 2,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    we,
    input  logic [LANES-1:0]        lane_en,
    input  logic [ADDR_W-1:0]       waddr,
    input  logic [LANES*LANE_W-1:0] wdata,
    input  logic [ADDR_W-1:0]       raddr,
    output logic [LANES*LANE_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] cells [DEPTH];

        always_ff @(posedge clk) begin
            if (we && lane_en[g]) begin
                cells[waddr] <= wdata[g*LANE_W +: LANE_W];
            end
        end

        assign rdata[g*LANE_W +: LANE_W] = cells[raddr];
    end

endmodule

// File: rtl/sram_pipe_burst.sv
module sram_pipe_burst
    import sram_pkg::*;
#(
    parameter int ADDR_W  = 6,
    parameter int LANES   = 2,
    parameter int LANE_W  = 9,
    parameter int BURST_W = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic                    adsp_n,
    input  logic                    adsc_n,
    input  logic                    adv_n,
    input  logic                    ce1_n,
    input  logic                    ce2,
    input  logic                    ce3_n,
    input  logic                    gw_n,
    input  logic                    bwe_n,
    input  logic [LANES-1:0]        bw_n,
    input  logic                    oe_n,
    input  logic                    burst_linear,
    input  logic [LANES*LANE_W-1:0] din,
    output logic [LANES*LANE_W-1:0] dout,
    output logic                    dout_en
);

    localparam int DATA_W = LANES * LANE_W;

    typedef struct packed {
        acc_kind_e         kind;
        logic [ADDR_W-1:0] addr;
        logic [LANES-1:0]  lanes;
        logic [DATA_W-1:0] data;
    } stage_t;

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] data;
    } outreg_t;

    acc_kind_e         dec_kind;
    logic              dec_load;
    logic              dec_adv;
    logic [LANES-1:0]  dec_lanes;
    logic [ADDR_W-1:0] acc_addr;
    logic              burst_on;
    logic [DATA_W-1:0] arr_rdata;

    stage_t  st_d, st_q;
    outreg_t ov_d, ov_q;

    sram_cycle_decode #(
        .LANES (LANES)
    ) u_decode (
        .clk          (clk),
        .rst_n        (rst_n),
        .adsp_n       (adsp_n),
        .adsc_n       (adsc_n),
        .adv_n        (adv_n),
        .ce1_n        (ce1_n),
        .ce2          (ce2),
        .ce3_n        (ce3_n),
        .gw_n         (gw_n),
        .bwe_n        (bwe_n),
        .bw_n         (bw_n),
        .burst_active (burst_on),
        .kind         (dec_kind),
        .load_base    (dec_load),
        .advance      (dec_adv),
        .lane_we      (dec_lanes)
    );

    sram_burst_addr #(
        .ADDR_W  (ADDR_W),
        .BURST_W (BURST_W)
    ) u_burst (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (dec_load),
        .advance  (dec_adv),
        .clear    (dec_kind == ACC_DESEL),
        .linear   (burst_linear),
        .addr_in  (addr),
        .acc_addr (acc_addr),
        .active   (burst_on)
    );

    sram_byte_array #(
        .ADDR_W (ADDR_W),
        .LANES  (LANES),
        .LANE_W (LANE_W)
    ) u_array (
        .clk     (clk),
        .we      (st_q.kind == ACC_WRITE),
        .lane_en (st_q.lanes),
        .waddr   (st_q.addr),
        .wdata   (st_q.data),
        .raddr   (st_q.addr),
        .rdata   (arr_rdata)
    );

    always_comb begin
        st_d.kind  = dec_kind;
        st_d.addr  = acc_addr;
        st_d.lanes = dec_lanes;
        st_d.data  = din;

        ov_d = ov_q;
        // a registered read reaches the pad unless this edge deselects or writes
        ov_d.valid = (st_q.kind == ACC_READ)
                     && (dec_kind != ACC_DESEL)
                     && (dec_kind != ACC_WRITE);
        if (st_q.kind == ACC_READ) begin
            ov_d.data = arr_rdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{kind: ACC_NONE, addr: '0, lanes: '0, data: '0};
            ov_q <= '0;
        end else begin
            st_q <= st_d;
            ov_q <= ov_d;
        end
    end

    assign dout    = ov_q.data;
    assign dout_en = ov_q.valid && !oe_n;

    // R8: a sampled write cycle turns the drivers off
    a_r8_write_off: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_kind == ACC_WRITE) |=> !dout_en);

    // R7: a sampled deselect turns the drivers off at once
    a_r7_desel_off: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_kind == ACC_DESEL) |=> !dout_en);

    // R6: valid output only follows a registered read
    a_r6_read_latency: assert property (@(posedge clk) disable iff (!rst_n)
        ov_q.valid |-> ($past(st_q.kind) == ACC_READ));

    // R12: the pad is never driven while output enable is high
    a_r12_oe_gate: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> !dout_en);

endmodule

// File: tb/sim_sram_pipe_burst.sv
`timescale 1ns/1ps
module sim_sram_pipe_burst;

    localparam int AW = 6;
    localparam int DW = 18;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          adsp_n, adsc_n, adv_n, ce1_n, ce2, ce3_n;
    logic          gw_n, bwe_n, oe_n, burst_linear;
    logic [1:0]    bw_n;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] dout;
    logic          dout_en;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // bench reference state
    logic [DW-1:0] ref_mem [64];
    bit            m_act = 0;
    logic [AW-1:0] m_base = '0;
    logic [1:0]    m_step = '0;
    int            prev_kind = 0;
    logic [AW-1:0] prev_addr = '0;
    logic [1:0]    prev_lw = '0;
    logic [DW-1:0] prev_data = '0;

    always #2.5 clk = ~clk;

    sram_pipe_burst u0 (
        .clk(clk), .rst_n(rst_n), .addr(addr), .adsp_n(adsp_n), .adsc_n(adsc_n),
        .adv_n(adv_n), .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n), .gw_n(gw_n),
        .bwe_n(bwe_n), .bw_n(bw_n), .oe_n(oe_n), .burst_linear(burst_linear),
        .din(din), .dout(dout), .dout_en(dout_en)
    );

    function automatic logic [DW-1:0] pat(input int a, input int salt);
        return DW'((a * 5281 + salt * 977 + 1234) & 18'h3ffff);
    endfunction

    task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle();
        adsp_n = 1; adsc_n = 1; adv_n = 1;
        ce1_n = 0; ce2 = 1; ce3_n = 0;
        gw_n = 1; bwe_n = 1; bw_n = 2'b11; oe_n = 0;
    endtask

    // one clock: predict from the requirements, then compare after the edge
    task automatic tick(input string tag);
        bit         sel, wr, exp_v;
        logic [1:0] lw, lsb;
        logic [AW-1:0] a;
        logic [DW-1:0] exp_d;
        int         kind;
        sel = !ce1_n && ce2 && !ce3_n;
        lw  = !gw_n ? 2'b11 : (!bwe_n ? ~bw_n : 2'b00);
        wr  = |lw;
        a   = addr;
        kind = 0;
        if (!adsp_n && !ce1_n) begin
            if (sel) begin kind = 1; m_base = addr; m_step = 0; m_act = 1; lw = 0; end
            else begin kind = 3; m_act = 0; end
        end else if (!adsc_n) begin
            if (sel) begin kind = wr ? 2 : 1; m_base = addr; m_step = 0; m_act = 1; end
            else begin kind = 3; m_act = 0; end
        end else if (m_act) begin
            if (!adv_n) m_step = m_step + 1'b1;
            lsb  = burst_linear ? m_base[1:0] + m_step : m_base[1:0] ^ m_step;
            a    = {m_base[AW-1:2], lsb};
            kind = wr ? 2 : 1;
        end
        @(posedge clk);
        if (prev_kind == 2) begin
            if (prev_lw[0]) ref_mem[prev_addr][8:0]  = prev_data[8:0];
            if (prev_lw[1]) ref_mem[prev_addr][17:9] = prev_data[17:9];
        end
        exp_v = (prev_kind == 1) && (kind != 2) && (kind != 3);
        exp_d = ref_mem[prev_addr];
        prev_kind = kind; prev_addr = a; prev_lw = lw; prev_data = din;
        @(negedge clk);
        check({tag, " dout_en"}, DW'(dout_en), DW'(exp_v && !oe_n));
        if (exp_v && !oe_n) check({tag, " dout"}, dout, exp_d);
    endtask

    task automatic deselect(input string tag);
        idle(); ce2 = 0; adsc_n = 0;
        tick(tag);
        idle();
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 64; i++) ref_mem[i] = '0;
        idle();
        burst_linear = 1;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check("R11 reset dout_en", DW'(dout_en), '0);

        // R4: controller-strobe global writes load every word
        for (int a = 0; a < 64; a++) begin
            idle(); adsc_n = 0; gw_n = 0; addr = AW'(a); din = pat(a, 0);
            tick("R4");
        end
        // R6: back-to-back processor-strobe reads over the whole array
        for (int a = 0; a < 64; a++) begin
            idle(); adsp_n = 0; addr = AW'(a);
            tick("R6");
        end
        deselect("R7");

        // R10/R9: bursts from each start, both orders, then suspend and deselect
        for (int m = 0; m < 2; m++) begin
            for (int s = 0; s < 4; s++) begin
                burst_linear = m[0];
                idle(); adsp_n = 0; addr = AW'(8 + 4 * m + s);
                tick("R7 first cycle after deselect");
                for (int b = 0; b < 3; b++) begin
                    idle(); adv_n = 0;
                    tick("R10");
                end
                idle(); adv_n = 1;
                tick("R9 suspend");
                tick("R9 suspend");
                deselect("R7");
            end
        end
        burst_linear = 1;

        // R5: every write-enable combination on one word
        for (int p = 0; p < 16; p++) begin
            idle(); adsc_n = 0; addr = AW'(40);
            gw_n = p[3]; bwe_n = p[2]; bw_n = p[1:0];
            din = pat(p, 7);
            tick("R5 write");
            idle(); adsp_n = 0; addr = AW'(40);
            tick("R5");
            deselect("R5 readback");
        end

        // R3/R8: processor start ignores write, next cycle writes same address
        idle(); adsp_n = 0; gw_n = 0; adv_n = 0; addr = AW'(50); din = pat(50, 3);
        tick("R3 start");
        idle(); gw_n = 0; din = pat(50, 9);
        tick("R8 write forces off");
        idle(); adsp_n = 0; addr = AW'(50);
        tick("R3");
        deselect("R3 readback");

        // R2: both strobes low with write enables: a read, no write
        idle(); adsp_n = 0; adsc_n = 0; gw_n = 0; addr = AW'(51); din = 18'h2aaaa;
        tick("R2");
        idle(); adsp_n = 0; addr = AW'(51);
        tick("R2");
        deselect("R2 readback");

        // R1: processor strobe ignored while ce1_n high; read at 20 is suspended
        idle(); adsp_n = 0; addr = AW'(20);
        tick("R1 start");
        idle(); ce1_n = 1; adsp_n = 0; addr = AW'(33);
        tick("R1");
        idle();
        tick("R1 held address");
        idle(); ce1_n = 1; adsc_n = 0; addr = AW'(33);
        tick("R1 deselect");
        idle(); ce3_n = 1; adsp_n = 0; addr = AW'(34);
        tick("R1 ce3 off");
        idle();
        tick("R1 no access");

        // R12: output enable high during a read
        idle(); adsp_n = 0; addr = AW'(21);
        tick("R12 start");
        idle(); oe_n = 1;
        tick("R12");
        oe_n = 0; #0.1;
        check("R12 async on", DW'(dout_en), DW'(1));
        check("R12 data", dout, ref_mem[21]);
        oe_n = 1; #0.1;
        check("R12 async off", DW'(dout_en), '0);
        deselect("R7");

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule